// File: doc/BRIEF.md
# SDRAM Column Burst Command Engine

This block is the device-side column logic for one open page of a synchronous DRAM. On every rising clock edge it decodes the four active-low command pins into a read, a write, a burst stop or a no-operation. It then steps through the column addresses of the burst and performs one access to a small internal page register file per edge. Write data is taken from the data input in step with the addresses. Read data leaves through a shift pipeline whose depth equals the programmed CAS latency, together with an output-enable for the bidirectional data pads.

A configuration word, loaded through a load strobe, sets the burst length (1, 2, 4, 8 or the whole page), the address order (sequential or interleave) and the CAS latency (2 or 3). Any new read or write cuts the running burst off at once and restarts at the new column with a full burst. Read words already in the latency pipeline keep draining. A stop ends the burst, and the output enable falls only after the latency pipeline has emptied.

The burst controller is a three-state machine. The states are ST_IDLE (no burst), ST_READ (read burst in progress) and ST_WRITE (write burst in progress). The transitions are:
- start-read: any state to ST_READ on a read command when the burst is longer than one word.
- start-write: any state to ST_WRITE on a write command when the burst is longer than one word.
- single: any state to ST_IDLE on a read or write with burst length 1.
- advance: ST_READ or ST_WRITE to itself while words remain.
- finish: ST_READ or ST_WRITE to ST_IDLE after the last word.
- stop: any state to ST_IDLE on a burst stop.
- hold: ST_IDLE to itself on a no-operation.

Top module: `sdram_col_engine`

## Requirements
- R1: Pins are sampled as {cs_n, ras_n, cas_n, we_n}. The value 0101 is Read, 0100 is Write and 0110 is Burst Stop. Every other value is a no-operation that leaves a running burst undisturbed.
- R2: When mode_load is high at an edge, mode_in is stored for later commands. mode_in[2:0] selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives the full page, and the reserved codes 4 to 6 give 1. mode_in[3] set selects interleave order. mode_in[4] set selects CAS latency 3, and clear selects latency 2.
- R3: A write at edge t with column c stores dq_in, sampled at edge t+k, into burst address a_k for k = 0 up to the burst length minus 1. Data presented after the burst has completed changes no location.
- R4: A read at edge t places the word at a_k on dq_out with dq_oe high during the cycle that follows edge t+k+CL-1. dq_oe is low whenever no read word is due.
- R5: In sequential order, a_k equals c with its low log2(BL) bits replaced by (c+k) modulo BL. The address wraps inside the block aligned to the burst length.
- R6: In interleave order, a_k equals c with its low log2(BL) bits replaced by (c XOR k) on those bits.
- R7: At full-page length, a_k is (c+k) modulo the page size whatever the order bit holds. The burst runs until a new command or a stop arrives.
- R8: A read that arrives during a read burst restarts a full burst at its own column. Earlier read words still in the pipeline appear on dq_out before the new words.
- R9: A write that arrives during a write burst abandons the remaining addresses of the old burst and writes a full burst from its own column.
- R10: A read that arrives during a write burst ends the write at that edge. Data on dq_in during that edge and later edges is not written.
- R11: A stop at edge t performs no access at that edge or after it. The last read word, from edge t-1, is still delivered, and dq_oe is low from the cycle following edge t+CL-1.
- R12: While rst_n is low, dq_oe is low, any burst is abandoned and the mode returns to length 1, sequential order and latency 2. Page contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, part of the command code |
| cas_n | input | 1 | Column strobe pin, part of the command code |
| we_n | input | 1 | Write enable pin, part of the command code |
| col_in | input | COL_W | Starting column for read and write commands |
| mode_load | input | 1 | Stores mode_in at the edge when high |
| mode_in | input | 5 | Burst length, order and latency settings |
| dq_in | input | DW | Write data from the pads |
| dq_out | output | DW | Read data to the pads, zero when not enabled |
| dq_oe | output | 1 | Output enable for the data pads |

## Verification
The bench builds the block with COL_W = 4 and DW = 8, which gives a page of sixteen words. With a page that small, a full-page burst wraps from the top column back to column 0 within a few cycles. Every location can also be preloaded with its own pattern, so any wrong address shows up as a wrong data value. Both latency settings are selected at run time through the mode word, and the length-8 blocks cover half the page, so the sequential and interleave wrap points are both visible.

// File: rtl/sdcol_pkg.sv
package sdcol_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } col_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_st_e;

    typedef struct packed {
        logic       lat3;
        logic       interleave;
        logic [2:0] len_code;
    } mode_cfg_t;

    localparam int MODE_W  = $bits(mode_cfg_t);
    localparam int MAX_LAT = 3;

endpackage

// File: rtl/sdcol_cmd_decode.sv
module sdcol_cmd_decode
    import sdcol_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output col_cmd_e cmd
);

    always_comb begin
        unique case ({cs_n, ras_n, cas_n, we_n})
            4'b0101: cmd = CMD_READ;
            4'b0100: cmd = CMD_WRITE;
            4'b0110: cmd = CMD_STOP;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdcol_burst_fsm.sv
module sdcol_burst_fsm
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  col_cmd_e         cmd,
    input  logic [COL_W-1:0] col_in,
    input  mode_cfg_t        mode,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic [COL_W-1:0] acc_addr
);

    burst_st_e        state_q, state_d;
    logic [COL_W-1:0] start_q, start_d;
    logic [COL_W-1:0] cnt_q, cnt_d;
    logic [COL_W-1:0] wrap_mask;
    logic             full_page;
    logic [COL_W-1:0] step_addr;

    // Length decode: wrap_mask is BL-1, all ones for a full page.
    always_comb begin
        full_page = (mode.len_code == 3'd7);
        unique case (mode.len_code)
            3'd1:    wrap_mask = COL_W'(1);
            3'd2:    wrap_mask = COL_W'(3);
            3'd3:    wrap_mask = COL_W'(7);
            3'd7:    wrap_mask = {COL_W{1'b1}};
            default: wrap_mask = '0;
        endcase
    end

    // Address of word cnt_q within the running burst.
    always_comb begin
        if (mode.interleave && !full_page)
            step_addr = (start_q & ~wrap_mask) | ((start_q ^ cnt_q) & wrap_mask);
        else
            step_addr = (start_q & ~wrap_mask) | ((start_q + cnt_q) & wrap_mask);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and access outputs.
    always_comb begin
        state_d  = state_q;
        start_d  = start_q;
        cnt_d    = cnt_q;
        acc_rd   = 1'b0;
        acc_wr   = 1'b0;
        acc_addr = step_addr;
        if (cmd == CMD_READ || cmd == CMD_WRITE) begin
            acc_rd   = (cmd == CMD_READ);
            acc_wr   = (cmd == CMD_WRITE);
            acc_addr = col_in;
            start_d  = col_in;
            cnt_d    = COL_W'(1);
            if (wrap_mask == '0)
                state_d = ST_IDLE;
            else
                state_d = (cmd == CMD_READ) ? ST_READ : ST_WRITE;
        end else if (cmd == CMD_STOP) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_READ, ST_WRITE: begin
                    acc_rd = (state_q == ST_READ);
                    acc_wr = (state_q == ST_WRITE);
                    cnt_d  = cnt_q + COL_W'(1);
                    if (!full_page && cnt_q == wrap_mask)
                        state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // R1
    access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_rd, acc_wr}));

    // R11
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |=> (state_q == ST_IDLE));

    // R8
    rd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && wrap_mask != '0) |=> (state_q == ST_READ && cnt_q == COL_W'(1)));

    // R10
    rd_over_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && cmd == CMD_READ) |-> (acc_rd && !acc_wr));

endmodule

// File: rtl/sdcol_page.sv
module sdcol_page #(
    parameter int COL_W = 8,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [COL_W-1:0] addr,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data
);

    localparam int DEPTH = 1 << COL_W;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[addr] <= wr_data;
    end

    assign rd_data = cells[addr];

endmodule

// File: rtl/sdcol_lat_pipe.sv
module sdcol_lat_pipe
    import sdcol_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat3,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    output logic          out_vld,
    output logic [DW-1:0] out_data
);

    logic          vld_q [MAX_LAT];
    logic [DW-1:0] dat_q [MAX_LAT];

    for (genvar i = 0; i < MAX_LAT; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) vld_q[i] <= 1'b0;
                else        vld_q[i] <= in_vld;
                dat_q[i] <= in_data;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) vld_q[i] <= 1'b0;
                else        vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
        end
    end

    always_comb begin
        if (lat3) begin
            out_vld  = vld_q[2];
            out_data = vld_q[2] ? dat_q[2] : '0;
        end else begin
            out_vld  = vld_q[1];
            out_data = vld_q[1] ? dat_q[1] : '0;
        end
    end

endmodule

// File: rtl/sdram_col_engine.sv
module sdram_col_engine
    import sdcol_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [COL_W-1:0] col_in,
    input  logic             mode_load,
    input  logic [4:0]       mode_in,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    col_cmd_e         cmd;
    mode_cfg_t        mode_q;
    logic             acc_rd;
    logic             acc_wr;
    logic [COL_W-1:0] acc_addr;
    logic [DW-1:0]    page_rdata;

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_load)
            mode_q <= mode_cfg_t'(mode_in[MODE_W-1:0]);
    end

    sdcol_cmd_decode i_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdcol_burst_fsm #(.COL_W(COL_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .col_in   (col_in),
        .mode     (mode_q),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr)
    );

    sdcol_page #(.COL_W(COL_W), .DW(DW)) i_page (
        .clk     (clk),
        .wr_en   (acc_wr),
        .addr    (acc_addr),
        .wr_data (dq_in),
        .rd_data (page_rdata)
    );

    sdcol_lat_pipe #(.DW(DW)) i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat3     (mode_q.lat3),
        .in_vld   (acc_rd),
        .in_data  (page_rdata),
        .out_vld  (dq_oe),
        .out_data (dq_out)
    );

    // R4
    oe_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(acc_rd, 2) || $past(acc_rd, 3)));

endmodule

// File: tb/test_sdram_col_engine.sv
`timescale 1ns/1ps
module test_sdram_col_engine;

    localparam int COL_W = 4;
    localparam int DW    = 8;
    localparam logic [3:0] P_NOP = 4'b0111, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_ST  = 4'b0110, P_DESEL = 4'b1100, P_ACT = 4'b0011;
    localparam int NV = 8;
    // {mode, start column, word count, addresses a7..a0 as nibbles}
    localparam logic [47:0] VEC [NV] = '{
        {8'h02, 4'h6, 4'h4, 32'h00005476},
        {8'h0A, 4'h5, 4'h4, 32'h00006745},
        {8'h13, 4'hD, 4'h8, 32'hCBA98FED},
        {8'h1B, 4'hD, 4'h8, 32'hAB89EFCD},
        {8'h01, 4'h3, 4'h2, 32'h00000023},
        {8'h19, 4'h8, 4'h2, 32'h00000098},
        {8'h00, 4'h9, 4'h1, 32'h00000009},
        {8'h05, 4'h2, 4'h1, 32'h00000002}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [COL_W-1:0] col_in = '0;
    logic             mode_load = 1'b0;
    logic [4:0]       mode_in = '0;
    logic [DW-1:0]    dq_in = '0;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [DW-1:0] exp_mem [16];

    always #4 clk = ~clk;

    sdram_col_engine #(.COL_W(COL_W), .DW(DW)) i_sdram_col_engine (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .col_in(col_in), .mode_load(mode_load), .mode_in(mode_in),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic step(input logic [3:0] pins, input logic [3:0] col, input logic [7:0] d);
        {cs_n, ras_n, cas_n, we_n} = pins;
        col_in = col;
        dq_in  = d;
        @(negedge clk);
    endtask

    task automatic chk_word(input string req, input logic [7:0] exp);
        n_cmp++;
        if (dq_oe !== 1'b1 || dq_out !== exp) begin
            n_bad++;
            $display("FAIL %s: actual oe=%b dq=%h expected oe=1 dq=%h", req, dq_oe, dq_out, exp);
        end
    endtask

    task automatic chk_off(input string req);
        n_cmp++;
        if (dq_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: actual oe=%b expected oe=0", req, dq_oe);
        end
    endtask

    task automatic set_mode(input logic [4:0] m);
        mode_load = 1'b1;
        mode_in   = m;
        step(P_NOP, 4'h0, 8'h00);
        mode_load = 1'b0;
    endtask

    task automatic rd_one(input logic [3:0] col, input string req);
        step(P_RD, col, 8'h00);
        step(P_NOP, 4'h0, 8'h00);
        chk_word(req, exp_mem[col]);
        step(P_NOP, 4'h0, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        chk_off("R12 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_off("R12 after reset");

        // Preload the page with single-word writes (R3, default length 1)
        for (int c = 0; c < 16; c++) begin
            step(P_WR, 4'(c), 8'(8'hA0 + c));
            exp_mem[c] = 8'(8'hA0 + c);
        end
        step(P_NOP, 4'h0, 8'h00);
        rd_one(4'h7, "R3 preload");

        // Table walk: orders, lengths, latencies (R2 R4 R5 R6)
        for (int e = 0; e < NV; e++) begin
            automatic logic [47:0] ent = VEC[e];
            automatic int cl = ent[44] ? 3 : 2;
            automatic int n  = int'(ent[35:32]);
            automatic string tag = ent[43] ? "R6 R4" : "R5 R4";
            set_mode(ent[44:40]);
            step(P_RD, ent[39:36], 8'h00);
            for (int j = 1; j <= cl - 1 + n; j++) begin
                step(P_NOP, 4'h0, 8'h00);
                if (j >= cl - 1 && j < cl - 1 + n)
                    chk_word(tag, exp_mem[ent[4*(j-cl+1) +: 4]]);
                else if (j == cl - 1 + n)
                    chk_off("R2 burst length end");
            end
            step(P_NOP, 4'h0, 8'h00);
        end

        // R7 full-page write wrapping past the top, cut by a stop (R11)
        set_mode(5'h07);
        for (int k = 0; k < 5; k++)
            step(k == 0 ? P_WR : P_NOP, 4'hE, 8'(8'h30 + k));
        step(P_ST, 4'h0, 8'h35);
        step(P_NOP, 4'h0, 8'h36);
        exp_mem[14] = 8'h30; exp_mem[15] = 8'h31;
        exp_mem[0]  = 8'h32; exp_mem[1]  = 8'h33; exp_mem[2] = 8'h34;

        // R7 full-page read, order bit set but ignored, latency 3, stopped
        set_mode(5'h1F);
        step(P_RD, 4'hE, 8'h00);
        for (int j = 1; j <= 8; j++) begin
            step(j == 6 ? P_ST : P_NOP, 4'h0, 8'h00);
            if (j >= 2 && j <= 7)
                chk_word("R7 full page", exp_mem[4'(14 + j - 2)]);
            else if (j == 8)
                chk_off("R11 stop release");
        end

        // R8 read interrupts read, length 4, latency 2
        set_mode(5'h02);
        step(P_RD, 4'h0, 8'h00);
        step(P_NOP, 4'h0, 8'h00); chk_word("R8 old word 0", exp_mem[0]);
        step(P_RD, 4'h8, 8'h00);  chk_word("R8 old word 1", exp_mem[1]);
        for (int j = 3; j <= 7; j++) begin
            step(P_NOP, 4'h0, 8'h00);
            if (j <= 6) chk_word("R8 new burst", exp_mem[8 + j - 3]);
            else        chk_off("R8 new burst end");
        end

        // R1 non-command pin codes do not disturb a running read
        step(P_RD, 4'h4, 8'h00);
        step(P_DESEL, 4'h0, 8'h00); chk_word("R1 word 0", exp_mem[4]);
        step(P_ACT, 4'hF, 8'h00);   chk_word("R1 word 1", exp_mem[5]);
        step(P_NOP, 4'h0, 8'h00);   chk_word("R1 word 2", exp_mem[6]);
        step(P_NOP, 4'h0, 8'h00);   chk_word("R1 word 3", exp_mem[7]);
        step(P_NOP, 4'h0, 8'h00);   chk_off("R1 end");

        // R11 stop during a length-8 read with latency 3
        set_mode(5'h13);
        step(P_RD, 4'h0, 8'h00);
        for (int j = 1; j <= 5; j++) begin
            step(j == 3 ? P_ST : P_NOP, 4'h0, 8'h00);
            if (j >= 2 && j <= 4) chk_word("R11 drained word", exp_mem[j - 2]);
            else if (j == 5)      chk_off("R11 oe after stop");
        end
        step(P_NOP, 4'h0, 8'h00);

        // R3 data after a length-2 write is ignored
        set_mode(5'h01);
        step(P_WR, 4'h4, 8'h50);
        step(P_NOP, 4'h0, 8'h51);
        step(P_NOP, 4'h0, 8'h52);
        step(P_NOP, 4'h0, 8'h53);
        exp_mem[4] = 8'h50; exp_mem[5] = 8'h51;

        // R9 write interrupts write, length 4
        set_mode(5'h02);
        step(P_WR, 4'h4, 8'h60);
        step(P_NOP, 4'h0, 8'h61);
        step(P_WR, 4'h9, 8'h70);
        step(P_NOP, 4'h0, 8'h71);
        step(P_NOP, 4'h0, 8'h72);
        step(P_NOP, 4'h0, 8'h73);
        step(P_NOP, 4'h0, 8'h7F);
        exp_mem[4] = 8'h60; exp_mem[5] = 8'h61;
        exp_mem[9] = 8'h70; exp_mem[10] = 8'h71; exp_mem[11] = 8'h72; exp_mem[8] = 8'h73;

        // R10 read interrupts write, length 4, latency 2
        step(P_WR, 4'h0, 8'h80);
        step(P_NOP, 4'h0, 8'h81);
        step(P_RD, 4'hC, 8'h82);
        step(P_NOP, 4'h0, 8'h83); chk_word("R10 read word 0", exp_mem[12]);
        step(P_NOP, 4'h0, 8'h84); chk_word("R10 read word 1", exp_mem[13]);
        step(P_NOP, 4'h0, 8'h00); chk_word("R10 read word 2", exp_mem[14]);
        step(P_NOP, 4'h0, 8'h00); chk_word("R10 read word 3", exp_mem[15]);
        step(P_NOP, 4'h0, 8'h00); chk_off("R10 read end");
        exp_mem[0] = 8'h80; exp_mem[1] = 8'h81;

        // Read back single words to inspect the page
        set_mode(5'h00);
        rd_one(4'h4, "R9 old burst head");
        rd_one(4'h5, "R3 second word");
        rd_one(4'h6, "R9 old burst tail dropped");
        rd_one(4'h7, "R3 ignored after burst");
        rd_one(4'h8, "R9 wrapped word");
        rd_one(4'h9, "R9 first word");
        rd_one(4'hB, "R9 third word");
        rd_one(4'hC, "R9 outside block");
        rd_one(4'h0, "R10 written before read");
        rd_one(4'h2, "R10 residual ignored");
        rd_one(4'h3, "R11 no write after stop");
        rd_one(4'h3, "R7 untouched after wrap");

        // R12 reset abandons a full-page burst and restores defaults
        set_mode(5'h07);
        step(P_RD, 4'h0, 8'h00);
        step(P_NOP, 4'h0, 8'h00);
        rst_n = 1'b0;
        step(P_NOP, 4'h0, 8'h00);
        step(P_NOP, 4'h0, 8'h00);
        chk_off("R12 reset mid burst");
        rst_n = 1'b1;
        step(P_NOP, 4'h0, 8'h00);
        step(P_NOP, 4'h0, 8'h00);
        chk_off("R12 no burst after reset");
        step(P_RD, 4'h5, 8'h00);
        step(P_NOP, 4'h0, 8'h00); chk_word("R12 default length", exp_mem[5]);
        step(P_NOP, 4'h0, 8'h00); chk_off("R12 default single word");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule